// File: doc/BRIEF.md
# Retirement-stage floating-point exception flag accumulator

This block keeps the floating-point exception flags of in-flight instructions apart from architectural state until those instructions retire. Each execution writeback stores five exception bits and one "FP state touched" bit into a commit slot. That slot is indexed by the instruction's commit position. The bits stay there while the instruction is still speculative. A mispredict flush clears any slot it names, so flags from squashed work never leave the block.

A retirement stage with several lanes names up to `LANES` slots per clock. The block ORs the stored bits of every valid lane in that same clock and folds the result into a sticky flags register. When any retiring instruction touched FP state, the block marks the FS status dirty. Slots that retire are emptied. The block also owns the rounding-mode register. A CSR write to that register raises a one-cycle flush request, but only when the value written differs from the value held.

The writeback, retire and CSR inputs are plain valid-qualified strobes with no ready signal. The block accepts every strobe in the cycle it is presented and never applies back-pressure. The retirement logic guarantees that a CSR access retires on its own.

Top module: `fp_flag_accum`

## Requirements
- R1: Reset sets the sticky flags to 0, the rounding mode to 0, FS to clean (2) and the flush request to 0, and it empties every slot. A slot retired after reset without a writeback contributes nothing.
- R2: A writeback stores `wb_flags` and `wb_fp_chg` in slot `wb_slot`. The stored bits do not change the sticky flags until that slot retires. Flag bit order is: bit0 inexact, bit1 underflow, bit2 overflow, bit3 divide-by-zero, bit4 invalid.
- R3: In a cycle with no flags CSR write, the stored flags of every lane whose `ret_valid` bit is set are ORed into the sticky flags. The result is visible one clock later. Lanes with `ret_valid` low contribute nothing. Lane i takes its slot index from `ret_slot[IDX_W*i +: IDX_W]`. Sticky bits are never cleared by retirement.
- R4: FS uses the encoding off=0, initial=1, clean=2, dirty=3. FS becomes dirty one clock after any valid retiring lane holds an FP-state-touched bit of 1. The same holds when the touching instruction raised no flags.
- R5: A 1 in bit s of `kill_mask` empties slot s. Kill has priority over a writeback to the same slot in the same cycle.
- R6: A slot that retires is emptied, so retiring it again contributes nothing. The exception is a slot that receives a writeback in the same cycle: it keeps the new value, and the retiring lane uses the old one.
- R7: A flags CSR write replaces the sticky flags with `csr_flags_wdata` one clock later. Retire flags from that cycle are discarded. Any flags or rounding-mode CSR write sets FS to dirty.
- R8: A rounding-mode write updates `frm_o` one clock later. `flush_req_o` is high for exactly that one clock if the written value differed from the held value, and stays low otherwise.
- R9: An FS CSR write sets FS to `csr_fs_wdata` one clock later. It takes priority over every dirty-marking source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_valid | input | 1 | Writeback strobe |
| wb_slot | input | IDX_W | Slot written by the writeback |
| wb_flags | input | 5 | Exception bits of the completing instruction |
| wb_fp_chg | input | 1 | Instruction modified FP state |
| kill_mask | input | NSLOT | Slots squashed by a mispredict flush |
| ret_valid | input | LANES | Per-lane retire strobe |
| ret_slot | input | LANES*IDX_W | Per-lane retiring slot index |
| csr_flags_we | input | 1 | Flags CSR write |
| csr_flags_wdata | input | 5 | Flags CSR write value |
| csr_rm_we | input | 1 | Rounding-mode CSR write |
| csr_rm_wdata | input | RM_W | Rounding-mode write value |
| csr_fs_we | input | 1 | FS status write |
| csr_fs_wdata | input | 2 | FS status write value |
| fflags_o | output | 5 | Sticky exception flags |
| frm_o | output | RM_W | Current rounding mode |
| fs_o | output | 2 | FS status |
| flush_req_o | output | 1 | One-cycle pipeline flush request |

## Verification
The hardest state to reach from the ports is a retire cycle in which several lanes are valid and the lanes left invalid still point at slots that hold flags. In that cycle a lane that is wrongly counted, or a missing slot clear, changes the OR. The bench reloads every slot with a known flag pattern before each table row. It then clears the sticky register and retires one wide cycle in which the idle lanes aim at flag-bearing slots. Kill-versus-writeback and writeback-versus-retire collisions on one slot are then driven as directed same-cycle cases.

// File: rtl/fp_flag_accum_pkg.sv
package fp_flag_accum_pkg;
  localparam int FLAG_W = 5;

  typedef enum logic [1:0] {
    FS_OFF     = 2'd0,
    FS_INITIAL = 2'd1,
    FS_CLEAN   = 2'd2,
    FS_DIRTY   = 2'd3
  } fs_state_e;

  typedef struct packed {
    logic              chg;
    logic [FLAG_W-1:0] flags;
  } slot_rec_t;
endpackage

// File: rtl/fp_flag_slot_store.sv
module fp_flag_slot_store
  import fp_flag_accum_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int IDX_W = $clog2(NSLOT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wb_valid,
  input  logic [IDX_W-1:0]       wb_slot,
  input  slot_rec_t              wb_rec,
  input  logic [NSLOT-1:0]       kill_mask,
  input  logic [NSLOT-1:0]       clr_mask,
  output slot_rec_t [NSLOT-1:0]  recs_o
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic hit;
    assign hit = wb_valid && (wb_slot == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n)           recs_o[s] <= '0;
      else if (kill_mask[s]) recs_o[s] <= '0;
      else if (hit)          recs_o[s] <= wb_rec;
      else if (clr_mask[s])  recs_o[s] <= '0;
    end
  end
endmodule

// File: rtl/fp_flag_retire_merge.sv
module fp_flag_retire_merge
  import fp_flag_accum_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int LANES = 8,
  parameter int IDX_W = $clog2(NSLOT)
) (
  input  slot_rec_t [NSLOT-1:0]   recs,
  input  logic [LANES-1:0]        ret_valid,
  input  logic [LANES*IDX_W-1:0]  ret_slot,
  output slot_rec_t               merged_o,
  output logic [NSLOT-1:0]        clr_mask_o
);
  slot_rec_t [LANES-1:0] lane_rec;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IDX_W-1:0] idx;
    assign idx         = ret_slot[IDX_W*l +: IDX_W];
    assign lane_rec[l] = ret_valid[l] ? recs[idx] : '0;
  end

  always_comb begin
    merged_o = '0;
    for (int l = 0; l < LANES; l++) begin
      merged_o = merged_o | lane_rec[l];
    end
  end

  always_comb begin
    clr_mask_o = '0;
    for (int l = 0; l < LANES; l++) begin
      if (ret_valid[l]) clr_mask_o[ret_slot[IDX_W*l +: IDX_W]] = 1'b1;
    end
  end
endmodule

// File: rtl/fp_flag_csr_state.sv
module fp_flag_csr_state
  import fp_flag_accum_pkg::*;
#(
  parameter int RM_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_rec_t         merged,
  input  logic              csr_flags_we,
  input  logic [FLAG_W-1:0] csr_flags_wdata,
  input  logic              csr_rm_we,
  input  logic [RM_W-1:0]   csr_rm_wdata,
  input  logic              csr_fs_we,
  input  logic [1:0]        csr_fs_wdata,
  output logic [FLAG_W-1:0] fflags_o,
  output logic [RM_W-1:0]   frm_o,
  output fs_state_e         fs_o,
  output logic              flush_req_o
);
  logic rm_differs;
  logic mark_dirty;

  assign rm_differs = csr_rm_we && (csr_rm_wdata != frm_o);
  assign mark_dirty = merged.chg || csr_flags_we || csr_rm_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fflags_o <= '0;
    end else if (csr_flags_we) begin
      fflags_o <= csr_flags_wdata;
    end else begin
      fflags_o <= fflags_o | merged.flags;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_o <= FS_CLEAN;
    end else if (csr_fs_we) begin
      fs_o <= fs_state_e'(csr_fs_wdata);
    end else if (mark_dirty) begin
      fs_o <= FS_DIRTY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_o       <= '0;
      flush_req_o <= 1'b0;
    end else begin
      flush_req_o <= rm_differs;
      if (csr_rm_we) frm_o <= csr_rm_wdata;
    end
  end
endmodule

// File: rtl/fp_flag_accum.sv
module fp_flag_accum
  import fp_flag_accum_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int LANES = 8,
  parameter int RM_W  = 3,
  localparam int IDX_W = $clog2(NSLOT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wb_valid,
  input  logic [IDX_W-1:0]       wb_slot,
  input  logic [4:0]             wb_flags,
  input  logic                   wb_fp_chg,
  input  logic [NSLOT-1:0]       kill_mask,
  input  logic [LANES-1:0]       ret_valid,
  input  logic [LANES*IDX_W-1:0] ret_slot,
  input  logic                   csr_flags_we,
  input  logic [4:0]             csr_flags_wdata,
  input  logic                   csr_rm_we,
  input  logic [RM_W-1:0]        csr_rm_wdata,
  input  logic                   csr_fs_we,
  input  logic [1:0]             csr_fs_wdata,
  output logic [4:0]             fflags_o,
  output logic [RM_W-1:0]        frm_o,
  output logic [1:0]             fs_o,
  output logic                   flush_req_o
);
  slot_rec_t [NSLOT-1:0] recs;
  slot_rec_t             wb_rec;
  slot_rec_t             merged;
  logic [NSLOT-1:0]      clr_mask;
  fs_state_e             fs_q;

  assign wb_rec.flags = wb_flags;
  assign wb_rec.chg   = wb_fp_chg;
  assign fs_o         = fs_q;

  fp_flag_slot_store #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_slot(wb_slot),
    .wb_rec(wb_rec), .kill_mask(kill_mask), .clr_mask(clr_mask), .recs_o(recs)
  );

  fp_flag_retire_merge #(.NSLOT(NSLOT), .LANES(LANES), .IDX_W(IDX_W)) u_merge (
    .recs(recs), .ret_valid(ret_valid), .ret_slot(ret_slot),
    .merged_o(merged), .clr_mask_o(clr_mask)
  );

  fp_flag_csr_state #(.RM_W(RM_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .merged(merged),
    .csr_flags_we(csr_flags_we), .csr_flags_wdata(csr_flags_wdata),
    .csr_rm_we(csr_rm_we), .csr_rm_wdata(csr_rm_wdata),
    .csr_fs_we(csr_fs_we), .csr_fs_wdata(csr_fs_wdata),
    .fflags_o(fflags_o), .frm_o(frm_o), .fs_o(fs_q), .flush_req_o(flush_req_o)
  );
endmodule

// File: rtl/fp_flag_accum_chk.sv
module fp_flag_accum_chk #(
  parameter int LANES = 8,
  parameter int RM_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] ret_valid,
  input logic             csr_flags_we,
  input logic [4:0]       csr_flags_wdata,
  input logic             csr_rm_we,
  input logic [RM_W-1:0]  csr_rm_wdata,
  input logic             csr_fs_we,
  input logic [1:0]       csr_fs_wdata,
  input logic [4:0]       fflags_o,
  input logic [RM_W-1:0]  frm_o,
  input logic [1:0]       fs_o,
  input logic             flush_req_o
);
  // R3: retirement only ever adds sticky bits
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_flags_we |=> ((fflags_o & $past(fflags_o)) == $past(fflags_o)));

  // R7: a flags write replaces the register even when lanes retire alongside it
  p_replace_r7: assert property (@(posedge clk) disable iff (!rst_n)
    csr_flags_we |=> (fflags_o == $past(csr_flags_wdata)));

  p_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_flags_we && !csr_fs_we && (ret_valid != '0)) |=> (fs_o == 2'd3));

  // R8: flush only on a real change of rounding mode
  p_flush_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rm_we && (csr_rm_wdata != frm_o)) |=> flush_req_o);

  p_no_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_rm_we && (csr_rm_wdata != frm_o)) |=> !flush_req_o);

  p_rm_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rm_we |=> (frm_o == $past(csr_rm_wdata)));

  // R9: software FS write wins
  p_fs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    csr_fs_we |=> (fs_o == $past(csr_fs_wdata)));
endmodule

bind fp_flag_accum fp_flag_accum_chk #(.LANES(LANES), .RM_W(RM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid),
  .csr_flags_we(csr_flags_we), .csr_flags_wdata(csr_flags_wdata),
  .csr_rm_we(csr_rm_we), .csr_rm_wdata(csr_rm_wdata),
  .csr_fs_we(csr_fs_we), .csr_fs_wdata(csr_fs_wdata),
  .fflags_o(fflags_o), .frm_o(frm_o), .fs_o(fs_o), .flush_req_o(flush_req_o)
);

// File: tb/fp_flag_accum_test.sv
module fp_flag_accum_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 16;
  localparam int LANES = 8;
  localparam int IDX_W = 4;

  // row: {ret_valid[8], lane slots[32] (lane7 high nibble), exp flags[5], exp fs-dirty[1]}
  localparam logic [45:0] VEC [0:7] = '{
    {8'h01, 32'h0000_0000, 5'h01, 1'b0},
    {8'h00, 32'h7654_3210, 5'h00, 1'b0},
    {8'hFF, 32'h7654_3210, 5'h1F, 1'b0},
    {8'h0A, 32'hECA8_6420, 5'h06, 1'b0},
    {8'h80, 32'hB000_0000, 5'h00, 1'b1},
    {8'h90, 32'hF003_0000, 5'h08, 1'b1},
    {8'h24, 32'h00D0_0900, 5'h10, 1'b1},
    {8'h07, 32'h0000_0C44, 5'h10, 1'b0}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic wb_valid = 0;
  logic [IDX_W-1:0] wb_slot = '0;
  logic [4:0] wb_flags = '0;
  logic wb_fp_chg = 0;
  logic [NSLOT-1:0] kill_mask = '0;
  logic [LANES-1:0] ret_valid = '0;
  logic [LANES*IDX_W-1:0] ret_slot = '0;
  logic csr_flags_we = 0;
  logic [4:0] csr_flags_wdata = '0;
  logic csr_rm_we = 0;
  logic [2:0] csr_rm_wdata = '0;
  logic csr_fs_we = 0;
  logic [1:0] csr_fs_wdata = '0;
  logic [4:0] fflags_o;
  logic [2:0] frm_o;
  logic [1:0] fs_o;
  logic flush_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_flag_accum uut (
    .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_slot(wb_slot),
    .wb_flags(wb_flags), .wb_fp_chg(wb_fp_chg), .kill_mask(kill_mask),
    .ret_valid(ret_valid), .ret_slot(ret_slot),
    .csr_flags_we(csr_flags_we), .csr_flags_wdata(csr_flags_wdata),
    .csr_rm_we(csr_rm_we), .csr_rm_wdata(csr_rm_wdata),
    .csr_fs_we(csr_fs_we), .csr_fs_wdata(csr_fs_wdata),
    .fflags_o(fflags_o), .frm_o(frm_o), .fs_o(fs_o), .flush_req_o(flush_req_o)
  );

  function automatic logic [4:0] flag_of(int s);
    return (s < 10) ? 5'(1 << (s % 5)) : 5'h00;
  endfunction

  function automatic logic chg_of(int s);
    return (s >= 10) && (s % 2 == 1);
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_all();
    for (int s = 0; s < NSLOT; s++) begin
      wb_valid = 1; wb_slot = IDX_W'(s); wb_flags = flag_of(s); wb_fp_chg = chg_of(s);
      step();
    end
    wb_valid = 0;
  endtask

  task automatic clear_state();
    csr_flags_we = 1; csr_flags_wdata = 0; csr_fs_we = 1; csr_fs_wdata = 2'd2;
    step();
    csr_flags_we = 0; csr_fs_we = 0;
  endtask

  task automatic retire_one(int s);
    ret_valid = 8'h01; ret_slot = '0; ret_slot[IDX_W-1:0] = IDX_W'(s);
    step();
    ret_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1 fflags", 32'(fflags_o), 0);
    chk("R1 fs", 32'(fs_o), 2);
    chk("R1 frm", 32'(frm_o), 0);
    chk("R1 flush", 32'(flush_req_o), 0);
    ret_valid = 8'hFF; ret_slot = 32'hFEDC_BA98;
    step(); ret_valid = 0;
    chk("R1 empty slots", 32'(fflags_o), 0);
    chk("R1 fs clean after empty retire", 32'(fs_o), 2);

    // table walk: R3 OR of valid lanes, R4 FS dirty
    for (int v = 0; v < 8; v++) begin
      load_all();
      clear_state();
      ret_valid = VEC[v][45:38]; ret_slot = VEC[v][37:6];
      step();
      ret_valid = 0;
      chk($sformatf("R3 vec%0d flags", v), 32'(fflags_o), 32'(VEC[v][5:1]));
      chk($sformatf("R4 vec%0d fs", v), 32'(fs_o), VEC[v][0] ? 3 : 2);
    end

    // R2 stored flags stay out of architectural state before retire
    clear_state();
    wb_valid = 1; wb_slot = 5; wb_flags = 5'h1F; wb_fp_chg = 1;
    step(); wb_valid = 0;
    step();
    chk("R2 speculative flags hidden", 32'(fflags_o), 0);
    chk("R2 speculative fs clean", 32'(fs_o), 2);
    retire_one(5);
    chk("R2 flags after retire", 32'(fflags_o), 5'h1F);

    // R3 stickiness across retire cycles
    load_all(); clear_state();
    retire_one(0);
    retire_one(1);
    chk("R3 sticky accumulation", 32'(fflags_o), 5'h03);

    // R6 retire empties slot; same-cycle writeback keeps new value
    clear_state();
    retire_one(0);
    chk("R6 slot0 emptied", 32'(fflags_o), 0);
    wb_valid = 1; wb_slot = 2; wb_flags = 5'h10; wb_fp_chg = 0;
    ret_valid = 8'h01; ret_slot = 32'h2;
    step(); wb_valid = 0; ret_valid = 0;
    chk("R6 old value retired", 32'(fflags_o), 5'h04);
    clear_state();
    retire_one(2);
    chk("R6 new value kept", 32'(fflags_o), 5'h10);

    // R5 kill clears; kill beats writeback
    load_all(); clear_state();
    kill_mask = 16'h0008;
    step(); kill_mask = 0;
    retire_one(3);
    chk("R5 killed slot", 32'(fflags_o), 0);
    kill_mask = 16'h0002; wb_valid = 1; wb_slot = 1; wb_flags = 5'h1F; wb_fp_chg = 1;
    step(); kill_mask = 0; wb_valid = 0;
    retire_one(1);
    chk("R5 kill over writeback flags", 32'(fflags_o), 0);
    chk("R5 kill over writeback fs", 32'(fs_o), 2);

    // R7 CSR flags write replaces, retire discarded
    load_all(); clear_state();
    csr_flags_we = 1; csr_flags_wdata = 5'h08;
    ret_valid = 8'h01; ret_slot = 32'h0;
    step(); csr_flags_we = 0; ret_valid = 0;
    chk("R7 replace value", 32'(fflags_o), 5'h08);
    chk("R7 fs dirty", 32'(fs_o), 3);

    // R9 FS write beats retire dirty
    load_all(); clear_state();
    csr_fs_we = 1; csr_fs_wdata = 2'd1;
    ret_valid = 8'h01; ret_slot = 32'hB;
    step(); csr_fs_we = 0; ret_valid = 0;
    chk("R9 fs write priority", 32'(fs_o), 1);

    // R8 rounding mode flush only on change
    csr_rm_we = 1; csr_rm_wdata = 3'd3;
    step(); csr_rm_we = 0;
    chk("R8 flush on change", 32'(flush_req_o), 1);
    chk("R8 frm updated", 32'(frm_o), 3);
    step();
    chk("R8 flush one cycle", 32'(flush_req_o), 0);
    csr_rm_we = 1; csr_rm_wdata = 3'd3;
    step(); csr_rm_we = 0;
    chk("R8 no flush same value", 32'(flush_req_o), 0);
    chk("R8 frm held", 32'(frm_o), 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule